// File: doc/BRIEF.md
# Pixel Format Unpacker with Palette

This block sits in a display output path. Each cycle it can take one fetched pixel word and turn it into a 24-bit colour (8 bits each of red, green and blue) plus a one-bit alpha flag. A configuration input picks the source layout. The layouts are:

- 16-bit 5-6-5
- 16-bit 1-5-5-5 with an alpha flag
- 24-bit packed 8-8-8
- 32-bit 8-8-8 with an unused top byte
- 32-bit 8-8-8 with an alpha byte
- 8-bit indexed colour

Channels narrower than 8 bits are widened by copying their top bits into the new low bits.

Indexed pixels are looked up in an internal 256-entry palette of 24-bit colours. Software loads the palette in two steps. It first writes the colour into a data register, then issues a command word that carries a fixed tag and the entry index. A red/blue exchange is applied to the final colour. It is active when the format's own swap bit and a panel-level swap bit differ.

The input is a valid/ready stream and the output is a valid stream. Results appear exactly one cycle after the pixel is accepted. The ready signal is taken straight from downstream. Configuration is sampled together with each pixel.

Top module: `pix_unpack_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 after that edge. The pipeline comes out of reset empty.
- R2: `in_ready` equals `out_ready`. A pixel is accepted at an edge where `in_valid` and `out_ready` are both 1, and its result is on `out_valid`/`out_rgb`/`out_alpha` after that edge. When `out_ready` is 0, the output valid, colour and alpha hold their values.
- R3: Format code 0 (5-6-5) takes red from bits 15:11, green from 10:5 and blue from 4:0. Each 5-bit channel widens to `{c, c[4:2]}` and the 6-bit channel to `{c, c[5:4]}`. Alpha is 1. `out_rgb` is packed red 23:16, green 15:8, blue 7:0.
- R4: Format code 1 (1-5-5-5) takes the alpha flag from bit 15, red from 14:10, green from 9:5 and blue from 4:0. Each 5-bit channel widens as in R3.
- R5: Format code 2 (packed 8-8-8) takes red 23:16, green 15:8 and blue 7:0. Bits 31:24 are ignored and alpha is 1.
- R6: Format code 3 decodes bits 23:0 as in R5 with alpha 1. Format code 4 decodes the same bits, and its alpha is bit 31, the most significant bit of the alpha byte.
- R7: When `cfg_fmt_swap` XOR `cfg_panel_swap` is 1, the red and blue bytes of the result are exchanged. This applies to every format.
- R8: Format code 10 (indexed) uses bits 7:0 as a palette index when `cfg_lut_en` is 1, and the result is the stored colour with alpha 1. When `cfg_lut_en` is 0, the result is colour 0 with alpha 0.
- R9: A pulse on `pal_data_wr` loads `pal_data` into the palette data register. A pulse on `pal_cmd_wr` with `pal_cmd[15:8]` = 0x83 copies the data register into entry `pal_cmd[7:0]`. A command with any other upper byte changes no entry. The data register keeps its value, so one load can be committed to several entries.
- R10: Any format code other than 0, 1, 2, 3, 4 or 10 gives colour 0 with alpha 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 4 | Base format code |
| cfg_fmt_swap | input | 1 | Format-level red/blue swap (variant bit of the format index) |
| cfg_panel_swap | input | 1 | Panel-level red/blue swap |
| cfg_lut_en | input | 1 | Palette lookup enable for indexed mode |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_data | input | 32 | Fetched pixel word |
| pal_data_wr | input | 1 | Load palette data register |
| pal_data | input | 24 | Palette colour, red 23:16, green 15:8, blue 7:0 |
| pal_cmd_wr | input | 1 | Issue palette command |
| pal_cmd | input | 16 | Command: tag in 15:8, entry index in 7:0 |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Downstream ready |
| out_rgb | output | 24 | Decoded colour, red 23:16, green 15:8, blue 7:0 |
| out_alpha | output | 1 | Decoded alpha flag |

## Verification
The assertions watch these rules on every cycle:

- the empty pipeline after reset;
- the held output under back-pressure;
- the alpha-byte rule of code 4;
- the zero result for unsupported codes and for disabled lookup;
- the effect of palette commands on the addressed entry, whether the tag is correct or wrong.

The bit layouts, channel widening, swap combinations and palette contents can only be shown by the bench. It drives known words, loads the palette, reads entries back and compares every result with values computed from the requirements.

// File: rtl/pix_unpack_pkg.sv
// Package: shared constants, format codes and colour type for the pixel unpacker.
// Assumes 8-bit output channels; all layouts fit in a 32-bit word.
package pix_unpack_pkg;
    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;
    localparam int FMT_W = 4;
    localparam int TAG_W = 8;

    typedef enum logic [FMT_W-1:0] {
        FMT_565  = 4'd0,
        FMT_1555 = 4'd1,
        FMT_888P = 4'd2,
        FMT_888U = 4'd3,
        FMT_8888 = 4'd4,
        FMT_IDX  = 4'd10
    } fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Widen a 5-bit channel by copying its top bits downward.
    function automatic logic [CH_W-1:0] grow5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    // Widen a 6-bit channel by copying its top bits downward.
    function automatic logic [CH_W-1:0] grow6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction
endpackage

// File: rtl/pix_palette.sv
// Module: palette store with a staged data register and a tagged commit command.
// Assumes one write and one synchronous read per cycle; a read of an entry
// being committed in the same cycle returns the old contents.
module pix_palette
    import pix_unpack_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter logic [TAG_W-1:0] CMD_TAG = 8'h83,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CMD_W = TAG_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [RGB_W-1:0] data_in,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_in,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [RGB_W-1:0] rd_data
);
    logic [RGB_W-1:0] mem [DEPTH];
    logic [RGB_W-1:0] stage_q;
    logic             commit;
    logic [IDX_W-1:0] cmd_idx;

    assign cmd_idx = cmd_in[IDX_W-1:0];
    assign commit  = cmd_wr && (cmd_in[CMD_W-1:IDX_W] == CMD_TAG);

    // Hold the colour staged by software until a commit uses it.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else if (data_wr) stage_q <= data_in;
    end

    // Copy the staged colour into the addressed entry on a tagged command.
    always_ff @(posedge clk) begin
        if (commit) mem[cmd_idx] <= stage_q;
    end

    // Synchronous read port, advanced only when the pipeline moves.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    // R9
    commit_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> mem[$past(cmd_idx)] == $past(stage_q));

    // R9
    bad_tag_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !commit && !data_wr) |=> mem[$past(cmd_idx)] == $past(mem[cmd_idx]));
endmodule

// File: rtl/pix_decode.sv
// Module: combinational layout decoder from a pixel word to 24-bit colour and alpha.
// Assumes the word is at least 32 bits wide; the palette colour is already read.
module pix_decode
    import pix_unpack_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] word,
    input  logic [FMT_W-1:0] fmt,
    input  logic             lut_en,
    input  logic [RGB_W-1:0] pal_rgb,
    output rgb_t             rgb,
    output logic             alpha
);
    // Select channel fields and alpha source per format code.
    always_comb begin
        rgb   = '0;
        alpha = 1'b0;
        case (fmt)
            FMT_565: begin
                rgb.r = grow5(word[15:11]);
                rgb.g = grow6(word[10:5]);
                rgb.b = grow5(word[4:0]);
                alpha = 1'b1;
            end
            FMT_1555: begin
                rgb.r = grow5(word[14:10]);
                rgb.g = grow5(word[9:5]);
                rgb.b = grow5(word[4:0]);
                alpha = word[15];
            end
            FMT_888P, FMT_888U: begin
                rgb   = word[RGB_W-1:0];
                alpha = 1'b1;
            end
            FMT_8888: begin
                rgb   = word[RGB_W-1:0];
                alpha = word[31];
            end
            FMT_IDX: begin
                if (lut_en) begin
                    rgb   = pal_rgb;
                    alpha = 1'b1;
                end
            end
            default: begin
                rgb   = '0;
                alpha = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pix_unpack_top.sv
// Module: one-stage pixel unpacker. Captures pixel and configuration, reads the
// palette in the same stage and drives decoded colour one cycle later.
// Assumes downstream ready gates the whole stage; no buffering at the edges.
module pix_unpack_top
    import pix_unpack_pkg::*;
#(
    parameter int PIX_W = 32,
    parameter int PAL_DEPTH = 256,
    parameter logic [TAG_W-1:0] PAL_TAG = 8'h83,
    localparam int IDX_W = $clog2(PAL_DEPTH),
    localparam int CMD_W = TAG_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] cfg_fmt,
    input  logic             cfg_fmt_swap,
    input  logic             cfg_panel_swap,
    input  logic             cfg_lut_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             pal_data_wr,
    input  logic [RGB_W-1:0] pal_data,
    input  logic             pal_cmd_wr,
    input  logic [CMD_W-1:0] pal_cmd,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [RGB_W-1:0] out_rgb,
    output logic             out_alpha
);
    logic             take;
    logic             v_q;
    logic [PIX_W-1:0] word_q;
    logic [FMT_W-1:0] fmt_q;
    logic             swap_q;
    logic             lut_q;
    logic [RGB_W-1:0] pal_rgb;
    rgb_t             dec_rgb;
    logic             dec_alpha;

    assign in_ready = out_ready;
    assign take     = in_valid && out_ready;

    // Advance the stage when downstream is ready; capture config with the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            word_q <= '0;
            fmt_q  <= '0;
            swap_q <= 1'b0;
            lut_q  <= 1'b0;
        end else if (out_ready) begin
            v_q <= in_valid;
            if (in_valid) begin
                word_q <= in_data;
                fmt_q  <= cfg_fmt;
                swap_q <= cfg_fmt_swap ^ cfg_panel_swap;
                lut_q  <= cfg_lut_en;
            end
        end
    end

    pix_palette #(
        .DEPTH   (PAL_DEPTH),
        .CMD_TAG (PAL_TAG)
    ) pal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (pal_data_wr),
        .data_in (pal_data),
        .cmd_wr  (pal_cmd_wr),
        .cmd_in  (pal_cmd),
        .rd_en   (take),
        .rd_addr (in_data[IDX_W-1:0]),
        .rd_data (pal_rgb)
    );

    pix_decode #(
        .PIX_W (PIX_W)
    ) dec_i (
        .word    (word_q),
        .fmt     (fmt_q),
        .lut_en  (lut_q),
        .pal_rgb (pal_rgb),
        .rgb     (dec_rgb),
        .alpha   (dec_alpha)
    );

    // Apply the combined red/blue exchange to the decoded colour.
    always_comb begin
        if (swap_q) out_rgb = {dec_rgb.b, dec_rgb.g, dec_rgb.r};
        else        out_rgb = {dec_rgb.r, dec_rgb.g, dec_rgb.b};
    end

    assign out_valid = v_q;
    assign out_alpha = dec_alpha;

    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_alpha)));

    // R6
    alpha_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_q == FMT_8888) |-> out_alpha == word_q[31]);

    // R8
    lut_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_q == FMT_IDX && !lut_q) |-> (out_rgb == '0 && !out_alpha));

    // R10
    bad_fmt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(fmt_q inside {FMT_565, FMT_1555, FMT_888P, FMT_888U, FMT_8888, FMT_IDX}))
        |-> (out_rgb == '0 && !out_alpha));
endmodule

// File: tb/pix_unpack_top_tb_top.sv
// Bench: scoreboard for the pixel unpacker. The driver pushes expected
// results; a monitor pops and compares them as outputs appear.
module pix_unpack_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = '0;
    logic        cfg_fmt_swap = 1'b0, cfg_panel_swap = 1'b0, cfg_lut_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        pal_data_wr = 1'b0;
    logic [23:0] pal_data = '0;
    logic        pal_cmd_wr = 1'b0;
    logic [15:0] pal_cmd = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_rgb;
    logic        out_alpha;

    int checks = 0;
    int fails  = 0;
    logic [24:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] shadow [256];

    always #4 clk = ~clk;

    pix_unpack_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_fmt_swap(cfg_fmt_swap),
        .cfg_panel_swap(cfg_panel_swap), .cfg_lut_en(cfg_lut_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pal_data_wr(pal_data_wr), .pal_data(pal_data),
        .pal_cmd_wr(pal_cmd_wr), .pal_cmd(pal_cmd),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb), .out_alpha(out_alpha)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Expected {alpha, rgb} from the requirement text.
    function automatic logic [24:0] model(input logic [3:0] f, input logic fs, input logic ps,
                                          input logic lut, input logic [31:0] d);
        logic [7:0] r, g, b;
        logic a;
        r = 8'h00; g = 8'h00; b = 8'h00; a = 1'b0;
        case (f)
            4'd0: begin r = {d[15:11], d[15:13]}; g = {d[10:5], d[10:9]}; b = {d[4:0], d[4:2]}; a = 1'b1; end
            4'd1: begin r = {d[14:10], d[14:12]}; g = {d[9:5], d[9:7]}; b = {d[4:0], d[4:2]}; a = d[15]; end
            4'd2, 4'd3: begin r = d[23:16]; g = d[15:8]; b = d[7:0]; a = 1'b1; end
            4'd4: begin r = d[23:16]; g = d[15:8]; b = d[7:0]; a = d[31]; end
            4'd10: if (lut) begin {r, g, b} = shadow[d[7:0]]; a = 1'b1; end
            default: ;
        endcase
        if (fs ^ ps) return {a, b, g, r};
        return {a, r, g, b};
    endfunction

    task automatic send(input logic [3:0] f, input logic fs, input logic ps, input logic lut,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        cfg_fmt = f; cfg_fmt_swap = fs; cfg_panel_swap = ps; cfg_lut_en = lut;
        in_data = d; in_valid = 1'b1;
        exp_q.push_back(model(f, fs, ps, lut, d));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pal_load(input logic [23:0] c);
        @(negedge clk);
        pal_data_wr = 1'b1; pal_data = c;
        @(negedge clk);
        pal_data_wr = 1'b0;
    endtask

    task automatic pal_cmd_issue(input logic [7:0] tagb, input logic [7:0] idx, input logic [23:0] staged);
        @(negedge clk);
        pal_cmd_wr = 1'b1; pal_cmd = {tagb, idx};
        if (tagb == 8'h83) shadow[idx] = staged;
        @(negedge clk);
        pal_cmd_wr = 1'b0;
    endtask

    // Monitor: compare each delivered result with the scoreboard head.
    always @(negedge clk) begin
        #1;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", {7'd0, out_alpha, out_rgb}, 32'hFFFFFFFF);
            end else begin
                logic [24:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_alpha, out_rgb} === e, t, {7'd0, out_alpha, out_rgb}, {7'd0, e});
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        logic [31:0] lfsr;
        logic [24:0] held;
        lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid === 1'b0, "R1 reset out_valid", {31'd0, out_valid}, 32'd0);

        // 5-6-5 layout and widening
        send(4'd0, 0, 0, 0, 32'h0000_F800, "R3 565 red");
        send(4'd0, 0, 0, 0, 32'h0000_07E0, "R3 565 green");
        send(4'd0, 0, 0, 0, 32'h0000_001F, "R3 565 blue");
        send(4'd0, 0, 0, 0, 32'hFFFF_8410, "R3 565 mid");
        // swap combinations
        send(4'd0, 1, 0, 0, 32'h0000_F800, "R7 fmt swap");
        send(4'd0, 0, 1, 0, 32'h0000_F800, "R7 panel swap");
        send(4'd0, 1, 1, 0, 32'h0000_F800, "R7 both swap cancel");
        // 1-5-5-5
        send(4'd1, 0, 0, 0, 32'h0000_FC00, "R4 1555 alpha red");
        send(4'd1, 0, 0, 0, 32'h0000_03E0, "R4 1555 no alpha green");
        // 8-8-8 packed, unpacked, alpha
        send(4'd2, 0, 0, 0, 32'hAB12_3456, "R5 packed 888");
        send(4'd3, 1, 0, 0, 32'h00AB_CDEF, "R6 unpacked 888 swap");
        send(4'd4, 0, 0, 0, 32'h8011_2233, "R6 alpha byte set");
        send(4'd4, 0, 0, 0, 32'h7F44_5566, "R6 alpha byte clear");
        // unsupported codes
        send(4'd7, 0, 0, 1, 32'hFFFF_FFFF, "R10 code 7");
        send(4'd15, 0, 0, 1, 32'hFFFF_FFFF, "R10 code 15");
        idle();

        // palette loading
        pal_load(24'h10_20_30);
        pal_cmd_issue(8'h83, 8'd0, 24'h10_20_30);
        pal_cmd_issue(8'h83, 8'd255, 24'h10_20_30);
        pal_load(24'hC0_FF_EE);
        pal_cmd_issue(8'h83, 8'd5, 24'hC0_FF_EE);
        pal_load(24'h99_99_99);
        pal_cmd_issue(8'h82, 8'd5, 24'h99_99_99);
        pal_cmd_issue(8'h03, 8'd0, 24'h99_99_99);
        send(4'd10, 0, 0, 1, 32'h0000_0000, "R9 entry 0 from shared load");
        send(4'd10, 0, 0, 1, 32'hFFFF_FFFF, "R9 entry 255 from shared load");
        send(4'd10, 0, 0, 1, 32'h0000_0005, "R9 bad tag ignored");
        send(4'd10, 1, 0, 1, 32'h0000_0105, "R8 indexed swap low byte");
        send(4'd10, 0, 0, 0, 32'h0000_0005, "R8 lookup disabled");
        idle();

        // back-pressure: A delivered, B held at input
        send(4'd2, 0, 0, 0, 32'h005A_A53C, "R2 stall item A");
        held = model(4'd2, 0, 0, 0, 32'h005A_A53C);
        send(4'd0, 0, 0, 0, 32'h0000_1234, "R2 stall item B");
        out_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check(out_valid === 1'b1 && {out_alpha, out_rgb} === held, "R2 hold under stall",
                  {6'd0, out_valid, out_alpha, out_rgb}, {6'd0, 1'b1, held});
        end
        @(negedge clk);
        out_ready = 1'b1;
        idle();

        // back-to-back sweep over the direct formats
        for (int i = 0; i < 48; i++) begin
            logic [3:0] f;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (i % 6)
                0: f = 4'd0; 1: f = 4'd1; 2: f = 4'd2;
                3: f = 4'd3; 4: f = 4'd4; default: f = 4'd9;
            endcase
            send(f, lfsr[3], lfsr[9], lfsr[5], lfsr, "R3 R4 R5 R6 R7 R10 sweep");
        end
        idle();

        // reset while output is valid
        send(4'd2, 0, 0, 0, 32'h0012_3456, "R1 item before reset");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R1 reset clears valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 32'd0);
        report();
    end
endmodule